// File: doc/BRIEF.md
# Single-Control Three-Level Boost PWM Generator

This block drives the four switches of a three-level boost stage built from two interconnected half bridges. A symmetric triangular carrier comes from an up/down counter, and one scalar control value `c` sets all four gates. The block derives four comparison thresholds from `c`: `c/2` and `c` above the carrier midpoint, and `-c` and `-c/2` below it. It compares each threshold with the carrier and registers the results onto the gate lines. The gates of one half bridge conduct around the carrier peak. The gates of the other conduct around the valley, so the two pairs sit half a carrier period apart. Within each pair the outer switch is always wider than the inner one.

`c` comes from a feedforward map of a sampled input-voltage word: `c = slope * vin + offset`. The result is saturated so every duty stays between 0 and one half. As the source voltage moves, the duty cycles track it with no feedback loop. A new `c` only takes effect at a carrier turning point, so each ramp of the carrier is compared against a single threshold set. A one-cycle strobe marks every carrier peak.

Fixed point: `c` and the carrier share one scale. `2**FRAC` (default 256) stands for 1.0, which is also the half-period of the carrier in clocks.

Top module: `tlpwm_gen`

## Requirements
- R1: While reset is high, all four gates and the peak strobe are low. After reset, `c` holds 1.0 (full scale). The carrier starts at its lowest value counting up, so the first peak strobe appears on the (H+1)-th clock after reset is released, where H = 2**FRAC.
- R2: The carrier period is 2H clocks, and `peak_o` is high for exactly one clock in each period.
- R3: Gate 1 (`gate_o[0]`) and gate 4 (`gate_o[3]`) are each high for a fraction 0.5 - 0.25c of a carrier period, within two clocks, and their widths match within one clock.
- R4: Gate 2 (`gate_o[1]`) and gate 3 (`gate_o[2]`) are each high for a fraction 0.5 - 0.5c of a carrier period, within two clocks.
- R5: Gates 1 and 4 are never high in the same clock, and neither are gates 2 and 3. Gates 1 and 2 are centred on the carrier peak; gates 3 and 4 are centred on the valley.
- R6: Gate 2 high implies gate 1 high, and gate 3 high implies gate 4 high.
- R7: On a clock with `vin_valid_i` high, the pending control becomes floor(`slope_i` * `vin_i` / 2**SLOPE_F) + `offset_i`, in units where H = 1.0. `slope_i` and `offset_i` are signed two's complement, and `vin_i` is unsigned.
- R8: The pending control is saturated to the range 0 to H: a negative result gives duty 0.5 on all gates, and a result above H gives the full-scale duties.
- R9: Changes on `vin_i`, `slope_i` or `offset_i` while `vin_valid_i` is low have no effect on any gate.
- R10: A new control value is applied only when the carrier is at its peak or valley. A strobe in mid-ramp leaves the rest of that ramp on the old thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_i | input | VIN_W | Sampled input-voltage word, unsigned |
| vin_valid_i | input | 1 | Strobe: `vin_i` and the coefficients are taken on this clock |
| slope_i | input | SLOPE_W | Signed slope, SLOPE_F fraction bits, control units per LSB of `vin_i` |
| offset_i | input | FRAC+3 | Signed intercept in control units (H = 1.0) |
| gate_o | output | 4 | Gate lines; bit 0 is gate 1, bit 3 is gate 4 |
| peak_o | output | 1 | One-clock strobe at each carrier peak |

## Verification
The feedforward path can change the pending control value in the middle of a live gate pulse, while the comparator is still timing that pulse's trailing edge. The bench provokes this by strobing a much larger `c` halfway down the falling ramp, while gate 4 is active. It then counts the high cycles of gate 4 on each side of the valley. The half before the valley must match the old width and the half after must match the new one, which separates turning-point latching from immediate use.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;

    // Default sizing: carrier half period 2**FRAC clocks, which is also 1.0 of c
    parameter int FRAC_DEF    = 8;
    parameter int VIN_W_DEF   = 12;
    parameter int SLOPE_W_DEF = 16;
    parameter int SLOPE_F_DEF = 12;

    typedef enum logic {
        RAMP_UP = 1'b0,
        RAMP_DN = 1'b1
    } ramp_t;

    typedef struct packed {
        logic q4;
        logic q3;
        logic q2;
        logic q1;
    } gates_t;

    // Carrier in normalised form is s = (2*u - half)/half, and c is c_q/half.
    // q1: s >  c/2    q2: s >  c    q3: s < -c    q4: s < -c/2
    function automatic gates_t gate_decide(input int u, input int c_q, input int half);
        gates_t g;
        g.q1 = (4 * u) > (2 * half + c_q);
        g.q2 = (2 * u) > (half + c_q);
        g.q3 = (2 * u + c_q) < half;
        g.q4 = (4 * u + c_q) < (2 * half);
        return g;
    endfunction

endpackage

// File: rtl/tlpwm_carrier.sv
module tlpwm_carrier
    import tlpwm_pkg::*;
#(
    parameter int FRAC = FRAC_DEF
) (
    input  logic              clk,
    input  logic              rst,
    output logic [FRAC:0]     cnt_o,
    output logic              at_end_o,
    output logic              peak_o
);
    localparam int          HALF  = 1 << FRAC;
    localparam int          CNT_W = FRAC + 1;
    localparam logic [FRAC:0] TOP  = CNT_W'(HALF);

    ramp_t dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            dir    <= RAMP_UP;
            peak_o <= 1'b0;
        end else begin
            peak_o <= (cnt_o == TOP);
            if (dir == RAMP_UP) begin
                cnt_o <= cnt_o + 1'b1;
                if (cnt_o == TOP - 1'b1) dir <= RAMP_DN;
            end else begin
                cnt_o <= cnt_o - 1'b1;
                if (cnt_o == CNT_W'(1)) dir <= RAMP_UP;
            end
        end
    end

    assign at_end_o = (cnt_o == '0) || (cnt_o == TOP);

    // R2: carrier moves one step every clock and never leaves 0..HALF
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == $past(cnt_o) - 1'b1)));
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= TOP);
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        peak_o |=> !peak_o);

endmodule

// File: rtl/tlpwm_ffwd.sv
module tlpwm_ffwd
    import tlpwm_pkg::*;
#(
    parameter int FRAC    = FRAC_DEF,
    parameter int VIN_W   = VIN_W_DEF,
    parameter int SLOPE_W = SLOPE_W_DEF,
    parameter int SLOPE_F = SLOPE_F_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VIN_W-1:0]     vin_i,
    input  logic                 vin_valid_i,
    input  logic [SLOPE_W-1:0]   slope_i,
    input  logic [FRAC+2:0]      offset_i,
    output logic [FRAC:0]        c_o
);
    localparam int HALF   = 1 << FRAC;
    localparam int CTL_W  = FRAC + 1;
    localparam int PROD_W = SLOPE_W + VIN_W + 1;
    localparam int SUM_W  = ((PROD_W > FRAC + 3) ? PROD_W : FRAC + 3) + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum;
    logic        [CTL_W-1:0]  c_nxt;

    always_comb begin
        prod = PROD_W'($signed(slope_i)) * $signed({{(PROD_W-VIN_W){1'b0}}, vin_i});
        sum  = SUM_W'(prod >>> SLOPE_F) + SUM_W'($signed(offset_i));
        if (sum < 0)
            c_nxt = '0;
        else if (sum > $signed(SUM_W'(HALF)))
            c_nxt = CTL_W'(HALF);
        else
            c_nxt = sum[CTL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            c_o <= CTL_W'(HALF);
        else if (vin_valid_i)
            c_o <= c_nxt;
    end

    // R9: without a strobe the pending control holds
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !vin_valid_i |=> $stable(c_o));
    // R8: pending control never leaves 0..1.0
    a_r8_saturated: assert property (@(posedge clk) disable iff (rst)
        c_o <= CTL_W'(HALF));

endmodule

// File: rtl/tlpwm_gates.sv
module tlpwm_gates
    import tlpwm_pkg::*;
#(
    parameter int FRAC = FRAC_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FRAC:0] cnt_i,
    input  logic          at_end_i,
    input  logic [FRAC:0] c_pend_i,
    output gates_t        gates_o
);
    localparam int HALF  = 1 << FRAC;
    localparam int CTL_W = FRAC + 1;

    logic [FRAC:0] c_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_act   <= CTL_W'(HALF);
            gates_o <= '0;
        end else begin
            if (at_end_i) c_act <= c_pend_i;
            gates_o <= gate_decide(int'(cnt_i), int'(c_act), HALF);
        end
    end

    // R1: gates are low right after a reset clock
    a_r1_gates_low: assert property (@(posedge clk)
        $past(rst) |-> (gates_o == '0));
    // R5: the two gates of a pair never conduct together
    a_r5_pair14_apart: assert property (@(posedge clk) disable iff (rst)
        !(gates_o.q1 && gates_o.q4));
    a_r5_pair23_apart: assert property (@(posedge clk) disable iff (rst)
        !(gates_o.q2 && gates_o.q3));
    // R6: inner pulse lies within the outer pulse
    a_r6_nest_2in1: assert property (@(posedge clk) disable iff (rst)
        gates_o.q2 |-> gates_o.q1);
    a_r6_nest_3in4: assert property (@(posedge clk) disable iff (rst)
        gates_o.q3 |-> gates_o.q4);
    // R10: applied control changes only after a turning point
    a_r10_turn_only: assert property (@(posedge clk) disable iff (rst)
        (c_act != $past(c_act)) |-> $past(at_end_i));

endmodule

// File: rtl/tlpwm_gen.sv
module tlpwm_gen
    import tlpwm_pkg::*;
#(
    parameter int FRAC    = FRAC_DEF,
    parameter int VIN_W   = VIN_W_DEF,
    parameter int SLOPE_W = SLOPE_W_DEF,
    parameter int SLOPE_F = SLOPE_F_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VIN_W-1:0]   vin_i,
    input  logic               vin_valid_i,
    input  logic [SLOPE_W-1:0] slope_i,
    input  logic [FRAC+2:0]    offset_i,
    output logic [3:0]         gate_o,
    output logic               peak_o
);
    logic [FRAC:0] cnt;
    logic          at_end;
    logic [FRAC:0] c_pend;
    gates_t        gates;

    tlpwm_carrier #(.FRAC(FRAC)) u_carrier (
        .clk      (clk),
        .rst      (rst),
        .cnt_o    (cnt),
        .at_end_o (at_end),
        .peak_o   (peak_o)
    );

    tlpwm_ffwd #(
        .FRAC    (FRAC),
        .VIN_W   (VIN_W),
        .SLOPE_W (SLOPE_W),
        .SLOPE_F (SLOPE_F)
    ) u_ffwd (
        .clk         (clk),
        .rst         (rst),
        .vin_i       (vin_i),
        .vin_valid_i (vin_valid_i),
        .slope_i     (slope_i),
        .offset_i    (offset_i),
        .c_o         (c_pend)
    );

    tlpwm_gates #(.FRAC(FRAC)) u_gates (
        .clk      (clk),
        .rst      (rst),
        .cnt_i    (cnt),
        .at_end_i (at_end),
        .c_pend_i (c_pend),
        .gates_o  (gates)
    );

    assign gate_o = {gates.q4, gates.q3, gates.q2, gates.q1};

endmodule

// File: tb/tlpwm_gen_bench.sv
module tlpwm_gen_bench;
    localparam int FRAC    = tlpwm_pkg::FRAC_DEF;
    localparam int VIN_W   = tlpwm_pkg::VIN_W_DEF;
    localparam int SLOPE_W = tlpwm_pkg::SLOPE_W_DEF;
    localparam int SLOPE_F = tlpwm_pkg::SLOPE_F_DEF;
    localparam int H       = 1 << FRAC;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [VIN_W-1:0]   vin = '0;
    logic               vin_valid = 1'b0;
    logic [SLOPE_W-1:0] slope = '0;
    logic [FRAC+2:0]    offset = '0;
    logic [3:0]         gate;
    logic               peak;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tlpwm_gen u_tlpwm_gen (
        .clk         (clk),
        .rst         (rst),
        .vin_i       (vin),
        .vin_valid_i (vin_valid),
        .slope_i     (slope),
        .offset_i    (offset),
        .gate_o      (gate),
        .peak_o      (peak)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic wait_peak();
        do @(negedge clk); while (!peak);
    endtask

    task automatic apply(input int s, input int o, input int v);
        @(negedge clk);
        slope = SLOPE_W'(s);
        offset = (FRAC+3)'(o);
        vin = VIN_W'(v);
        vin_valid = 1'b1;
        @(negedge clk);
        vin_valid = 1'b0;
        wait_peak();
        wait_peak();
    endtask

    // Count high cycles over one full period starting at a peak sample
    task automatic measure(output int w1, output int w2, output int w3, output int w4,
                           output int ov, output int nest);
        w1 = 0; w2 = 0; w3 = 0; w4 = 0; ov = 0; nest = 0;
        wait_peak();
        for (int i = 0; i < 2 * H; i++) begin
            if (i != 0) @(negedge clk);
            w1 += int'(gate[0]); w2 += int'(gate[1]);
            w3 += int'(gate[2]); w4 += int'(gate[3]);
            if ((gate[0] && gate[3]) || (gate[1] && gate[2])) ov++;
            if ((gate[1] && !gate[0]) || (gate[2] && !gate[3])) nest++;
        end
    endtask

    task automatic check_duty(input int c_q, input string tag);
        int w1, w2, w3, w4, ov, nest;
        int e1 = H - c_q / 2;
        int e2 = H - c_q;
        measure(w1, w2, w3, w4, ov, nest);
        chk(absd(w1, e1) <= 2, {tag, " R3 gate1 width"}, w1, e1);
        chk(absd(w4, e1) <= 2, {tag, " R3 gate4 width"}, w4, e1);
        chk(absd(w1, w4) <= 1, {tag, " R3 gate1/gate4 match"}, w1, w4);
        chk(absd(w2, e2) <= 2, {tag, " R4 gate2 width"}, w2, e2);
        chk(absd(w3, e2) <= 2, {tag, " R4 gate3 width"}, w3, e2);
        chk(ov == 0, {tag, " R5 pair overlap"}, ov, 0);
        chk(nest == 0, {tag, " R6 nesting"}, nest, 0);
    endtask

    task automatic t_reset();
        int n;
        repeat (4) @(negedge clk);
        chk(gate == 4'b0000, "R1 gates in reset", int'(gate), 0);
        chk(peak == 1'b0, "R1 peak in reset", int'(peak), 0);
        rst = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!peak && n < 4 * H);
        chk(n == H + 1, "R1 first peak timing", n, H + 1);
        check_duty(H, "R1 default c");
    endtask

    task automatic t_period();
        int n, hi;
        wait_peak();
        n = 0; hi = 0;
        do begin
            @(negedge clk); n++;
            if (peak) hi++;
        end while (!peak && n < 4 * H);
        chk(n == 2 * H, "R2 peak spacing", n, 2 * H);
        @(negedge clk);
        chk(peak == 1'b0, "R2 strobe one clock", int'(peak), 0);
    endtask

    task automatic t_duty_sweep();
        int cs[5] = '{0, 64, 128, 200, 256};
        foreach (cs[i]) begin
            apply(0, cs[i], 0);
            check_duty(cs[i], $sformatf("sweep c=%0d", cs[i]));
        end
    endtask

    task automatic t_ffwd();
        int sl[3] = '{100, 100, -50};
        int vv[3] = '{2000, 3500, 1000};
        int of[3] = '{20, 20, 150};
        foreach (sl[i]) begin
            longint p = longint'(sl[i]) * longint'(vv[i]);
            int c = int'(p >>> SLOPE_F) + of[i];
            apply(sl[i], of[i], vv[i]);
            check_duty(c, $sformatf("R7 ffwd case %0d c=%0d", i, c));
        end
    endtask

    task automatic t_sat();
        apply(0, -100, 0);
        check_duty(0, "R8 low clamp");
        apply(0, 400, 0);
        check_duty(H, "R8 high clamp offset");
        apply(30000, 0, 4095);
        check_duty(H, "R8 high clamp product");
    endtask

    task automatic t_ignore();
        apply(0, 64, 0);
        @(negedge clk);
        slope = SLOPE_W'(20000); offset = (FRAC+3)'(-300); vin = VIN_W'(4000);
        wait_peak();
        wait_peak();
        check_duty(64, "R9 no strobe");
    endtask

    task automatic t_turn();
        int a, b;
        apply(0, 0, 0);
        wait_peak();
        repeat (H / 2) @(negedge clk);
        offset = (FRAC+3)'(H);
        vin_valid = 1'b1;
        a = 0; b = 0;
        for (int i = 0; i < H / 2; i++) begin
            @(negedge clk);
            vin_valid = 1'b0;
            a += int'(gate[3]);
        end
        for (int i = 0; i < H / 2; i++) begin
            @(negedge clk);
            b += int'(gate[3]);
        end
        chk(absd(a, H / 2) <= 2, "R10 old c before valley", a, H / 2);
        chk(absd(b, H / 4) <= 2, "R10 new c after valley", b, H / 4);
    endtask

    initial begin
        t_reset();
        t_period();
        t_duty_sweep();
        t_ffwd();
        t_sat();
        t_ignore();
        t_turn();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule